// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a free-running tick counter that guards a system against a hung program. In watchdog mode the count must be restarted by software before the selected interval runs out; if it is not, the block emits a one-cycle system reset request. In interval mode the same expiry sets a sticky interrupt flag instead, and the block serves as a periodic tick source. The block leaves reset already counting in watchdog mode with the longest interval, so software must either service it or reprogram it early.

All configuration goes through one 16-bit write port. A write is accepted only when its upper byte holds the key 8'h5A. Any write with a different upper byte changes nothing and requests a reset at once. The control value can be read back at any time. Counting advances on one of two clock-enable inputs: a fast one, or a slow auxiliary one.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `rd_data_o` reads 16'h6900, `wdt_rst_o` is 0 and `irq_o` is 0. This state is watchdog mode, not held, fast enable selected and interval code 00.
- R2: In watchdog mode (bit 4 = 0), `wdt_rst_o` goes high exactly 2^K enabled ticks after the count starts from zero. K is the tap of the selected interval. Restarting the count before that point prevents the reset.
- R3: The interval code sits in bits 1:0. Code 00 uses tap CNT_W-1 (/32768 at the default width), 01 uses CNT_W-3 (/8192), 10 uses CNT_W-7 (/512) and 11 uses CNT_W-10 (/64).
- R4: In interval mode (bit 4 = 1), expiry sets `irq_o` one cycle later and never raises `wdt_rst_o`.
- R5: `irq_o` stays set until a keyed write with bit 6 = 1 clears it. Bit 6 also reads back the flag.
- R6: A write whose upper byte is not 8'h5A leaves the control register and the count unchanged. It also raises `wdt_rst_o` in the following cycle, in either mode.
- R7: While the hold bit (bit 7) is 1, the count does not advance and nothing expires. On release, counting resumes from the held value.
- R8: A keyed write with the clear bit (bit 3) = 1 restarts the count from zero. Bit 3 always reads 0.
- R9: With the source bit (bit 2) = 1, only `slow_tick_i` advances the count and `fast_tick_i` is ignored. With bit 2 = 0, only `fast_tick_i` advances it.
- R10: `wdt_rst_o` is a single-cycle pulse for each expiry.
- R11: The upper byte of `rd_data_o` always reads 8'h69.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_tick_i | input | 1 | Fast count enable |
| slow_tick_i | input | 1 | Slow auxiliary count enable |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 16 | Control write data, key in bits 15:8 |
| rd_data_o | output | 16 | Control read value |
| wdt_rst_o | output | 1 | System reset request pulse |
| irq_o | output | 1 | Interval interrupt flag |

## Verification
The bench builds the block with CNT_W = 12, so the four taps give periods of 2048, 512, 32 and 4 ticks. At that width the longest power-up watchdog expiry and every interval can be measured to the exact cycle within a short run. The ratio between taps stays that of the full-width block. With the short taps, hold, restart, feeding and source selection each show their effect within a few dozen cycles.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;

  localparam int unsigned HOLD_B  = 7;
  localparam int unsigned IFLAG_B = 6;
  localparam int unsigned MODE_B  = 4;
  localparam int unsigned CLR_B   = 3;
  localparam int unsigned CSEL_B  = 2;

  typedef struct packed {
    logic       hold;
    logic       iv_mode;  // 1: interval, 0: watchdog
    logic       aux_clk;
    logic [1:0] isel;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{hold: 1'b0, iv_mode: 1'b0, aux_clk: 1'b0, isel: 2'b00};
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_guard_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              clr_o,
  output logic              irq_clr_o,
  output logic              bad_key_o
);
  logic  key_ok, good_wr;
  ctrl_t ctrl_q;

  assign key_ok    = (wr_data_i[DATA_W-1 -: 8] == WR_KEY);
  assign good_wr   = wr_en_i && key_ok;
  assign bad_key_o = wr_en_i && !key_ok;
  assign clr_o     = good_wr && wr_data_i[CLR_B];
  assign irq_clr_o = good_wr && wr_data_i[IFLAG_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (good_wr) begin
      ctrl_q.hold    <= wr_data_i[HOLD_B];
      ctrl_q.iv_mode <= wr_data_i[MODE_B];
      ctrl_q.aux_clk <= wr_data_i[CSEL_B];
      ctrl_q.isel    <= wr_data_i[1:0];
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = CNT_W - 1,
  parameter int unsigned TAP1  = CNT_W - 3,
  parameter int unsigned TAP2  = CNT_W - 7,
  parameter int unsigned TAP3  = CNT_W - 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [1:0] isel_i,
  output logic       expire_o
);
  localparam int unsigned NTAP = 4;
  localparam int unsigned TAPS [NTAP] = '{TAP0, TAP1, TAP2, TAP3};

  function automatic logic [CNT_W-1:0] low_ones(int unsigned k);
    return CNT_W'((64'd1 << k) - 64'd1);
  endfunction

  logic [CNT_W-1:0] masks [NTAP];
  logic [CNT_W-1:0] cnt_q, mask;
  logic             step;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign masks[g] = low_ones(TAPS[g]);
  end

  assign mask     = masks[isel_i];
  assign step     = tick_i && !hold_i && !clr_i;
  assign expire_o = step && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic iv_mode_i,
  input  logic bad_key_i,
  input  logic irq_clr_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic rst_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= (expire_i && !iv_mode_i) || bad_key_i;
      if (expire_i && iv_mode_i) irq_q <= 1'b1;  // set beats clear
      else if (irq_clr_i)        irq_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = CNT_W - 1,
  parameter int unsigned TAP1  = CNT_W - 3,
  parameter int unsigned TAP2  = CNT_W - 7,
  parameter int unsigned TAP3  = CNT_W - 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fast_tick_i,
  input  logic        slow_tick_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  output logic        wdt_rst_o,
  output logic        irq_o
);
  ctrl_t ctrl;
  logic  clr, irq_clr, bad_key, tick, expire;

  wdt_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .clr_o     (clr),
    .irq_clr_o (irq_clr),
    .bad_key_o (bad_key)
  );

  assign tick = ctrl.aux_clk ? slow_tick_i : fast_tick_i;

  wdt_counter #(
    .CNT_W (CNT_W),
    .TAP0  (TAP0),
    .TAP1  (TAP1),
    .TAP2  (TAP2),
    .TAP3  (TAP3)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hold_i   (ctrl.hold),
    .clr_i    (clr),
    .isel_i   (ctrl.isel),
    .expire_o (expire)
  );

  wdt_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .iv_mode_i (ctrl.iv_mode),
    .bad_key_i (bad_key),
    .irq_clr_i (irq_clr),
    .rst_req_o (wdt_rst_o),
    .irq_o     (irq_o)
  );

  assign rd_data_o = {RD_KEY, ctrl.hold, irq_o, 1'b0, ctrl.iv_mode,
                      1'b0, ctrl.aux_clk, ctrl.isel};
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_guard_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        wdt_rst_o,
  input logic        irq_o
);
  logic bad_wr, clr_wr;
  assign bad_wr = wr_en_i && (wr_data_i[15:8] != WR_KEY);
  assign clr_wr = wr_en_i && (wr_data_i[15:8] == WR_KEY) && wr_data_i[IFLAG_B];

  p_bad_key_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> wdt_rst_o);

  p_bad_key_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> ($stable(rd_data_o[7]) && $stable(rd_data_o[5:0])));

  p_iv_no_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[MODE_B] && !bad_wr) |=> !wdt_rst_o);

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o && !bad_wr) |=> !wdt_rst_o);

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);

  p_hold_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[HOLD_B] |=> !$rose(irq_o));

  p_rd_key_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15:8] == RD_KEY);

  p_clr_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[CLR_B]);
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .wdt_rst_o (wdt_rst_o),
  .irq_o     (irq_o)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int PER [4] = '{2048, 512, 32, 4};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fast_tick_i = 1'b1;
  logic        slow_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        wdt_rst_o, irq_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_guard #(.CNT_W(CNT_W)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fast_tick_i (fast_tick_i),
    .slow_tick_i (slow_tick_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .wdt_rst_o   (wdt_rst_o),
    .irq_o       (irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  // counts negedges until the chosen output is high; flags the other output
  task automatic wait_hi(input bit want_irq, input int lim, output int n, output bit other);
    n = 0;
    other = 1'b0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk_i);
      if (want_irq ? wdt_rst_o : irq_o) other = 1'b1;
      if (want_irq ? irq_o : wdt_rst_o) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic quiet(input int cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (wdt_rst_o || irq_o) seen = 1'b1;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check(rd_data_o == 16'h6900, "R1 reset read", rd_data_o, 16'h6900);
    check(rd_data_o[15:8] == 8'h69, "R11 read key", rd_data_o[15:8], 8'h69);
    check(!wdt_rst_o && !irq_o, "R1 outputs idle", {wdt_rst_o, irq_o}, 0);
  endtask

  task automatic t_powerup;
    int n; bit o;
    wait_hi(1'b0, 3000, n, o);
    check(n == PER[0], "R2 power-up expiry", n, PER[0]);
    @(negedge clk_i);
    check(!wdt_rst_o, "R10 single pulse", wdt_rst_o, 0);
  endtask

  task automatic t_taps;
    int n; bit o;
    for (int t = 0; t < 4; t++) begin
      wr(16'h5AC0);  // hold + clear flag
      check(!irq_o, "R5 flag cleared", irq_o, 0);
      wr(16'h5A18 | 16'(t));
      check(rd_data_o[7:0] == 8'(8'h10 | t), "R8 clear bit reads 0", rd_data_o[7:0], 8'h10 | t);
      wait_hi(1'b1, 3000, n, o);
      check(n == PER[t], "R3 interval period", n, PER[t]);
      check(!o, "R4 no reset in interval mode", o, 0);
    end
    repeat (10) @(negedge clk_i);
    check(irq_o, "R5 flag sticky", irq_o, 1);
  endtask

  task automatic t_hold;
    int n; bit o, s;
    wr(16'h5ADB);  // hold, clear flag, interval, restart, tap 11
    quiet(40, s);
    check(!s, "R7 held no expiry", s, 0);
    check(rd_data_o[7], "R7 hold reads back", rd_data_o[7], 1);
    wr(16'h5A13);
    wait_hi(1'b1, 100, n, o);
    check(n == PER[3], "R7 resume from held count", n, PER[3]);
  endtask

  task automatic t_restart;
    int n; bit o;
    wr(16'h5A5A);
    repeat (20) @(negedge clk_i);
    check(!irq_o, "R8 no early expiry", irq_o, 0);
    wr(16'h5A1A);
    wait_hi(1'b1, 200, n, o);
    check(n == PER[2], "R8 restart from zero", n, PER[2]);
  endtask

  task automatic t_bad_key;
    wr(16'h5AD3);
    wr(16'hA540);
    check(wdt_rst_o, "R6 bad key reset", wdt_rst_o, 1);
    check(rd_data_o == 16'h6993, "R6 register kept", rd_data_o, 16'h6993);
    @(negedge clk_i);
    check(!wdt_rst_o, "R10 bad key pulse width", wdt_rst_o, 0);
  endtask

  task automatic t_slow;
    int n; bit o, s;
    wr(16'h5A5F);
    check(rd_data_o[2], "R9 source bit reads back", rd_data_o[2], 1);
    quiet(30, s);
    check(!s, "R9 fast enable ignored", s, 0);
    slow_tick_i = 1'b1;
    wait_hi(1'b1, 100, n, o);
    check(n == PER[3], "R9 slow enable counts", n, PER[3]);
    slow_tick_i = 1'b0;
  endtask

  task automatic t_feed;
    int n; bit o, s, any;
    wr(16'h5A4A);  // watchdog, restart, clear flag, tap 10
    any = 1'b0;
    for (int k = 0; k < 5; k++) begin
      quiet(20, s);
      any |= s;
      wr(16'h5A0A);
    end
    check(!any, "R2 fed watchdog silent", any, 0);
    wait_hi(1'b0, 200, n, o);
    check(n == PER[2], "R2 starved watchdog fires", n, PER[2]);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_powerup;
        t_taps;
        t_hold;
        t_restart;
        t_bad_key;
        t_slow;
        t_feed;
      end
      begin
        repeat (150000) @(posedge clk_i);
        check(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule